// File: doc/BRIEF.md
# Control-Function Sequencer

This block runs a stored control program once per PWM period. The program is a list of command words held in a writable program memory. Each word selects a function type and gives three addresses in a shared variable RAM: two operands and one result. For each command the sequencer reads both operands from the RAM and hands them to an external function unit through a request/acknowledge handshake. It then writes the unit's result back to the result address. One function type can be used any number of times in a program, each time with different variables. The control structure can therefore be changed by rewriting memory, without changing any hardware.

A pass starts on a one-cycle period strobe. A cycle counter measures the pass against a period budget supplied on an input port. If the budget runs out before the stop command, the pass is abandoned and a sticky overrun flag is raised. A strobe that arrives while a pass is still running is dropped and also raises the flag. The host loads the program and the variables through simple write ports. It can read the variables back at any time.

Top module: `fseq_top`

## Requirements
- R1: A command word is 28 bits wide. Bits [27:24] are the opcode, [23:16] the first operand address, [15:8] the second operand address and [7:0] the result address. Opcode 4'hF stops the pass, and any other opcode is passed unchanged on `fu_sel`.
- R2: When idle, a high `pwm_tick` starts a pass. The pass executes program slots 0, 1, 2 and so on in order until it reaches a stop command.
- R3: For each non-stop command, the variables at the two operand addresses appear on `fu_a` and `fu_b`, and `fu_req` is raised. `fu_req`, `fu_sel`, `fu_a` and `fu_b` stay constant until `fu_ack`. `fu_result` is written to the result address in the acknowledge cycle.
- R4: A result written by one command is the operand value seen by any later command of the same pass. The same opcode may appear in several commands with different addresses.
- R5: A pass takes one cycle to fetch each command, one cycle to read its operands, and one cycle plus the acknowledge delay in the handshake. The stop command takes one more cycle. After a pass, `cycle_cnt` equals this total: 3·N + (sum of acknowledge delays) + 1 for N commands.
- R6: If `cycle_cnt` reaches `period_len` before the stop command, the pass is aborted. `overrun` is set, no further result is written, `busy` falls and `cycle_cnt` holds `period_len`. A pass that needs exactly `period_len` cycles completes without overrun.
- R7: A `pwm_tick` during a pass is not queued. It sets `overrun`, and the running pass continues unchanged.
- R8: `overrun` stays set until reset.
- R9: Host writes to the variable RAM and the program memory are ignored while `busy` is high. `var_rdata` shows the variable at `var_raddr` at any time.
- R10: After reset, `busy`, `overrun`, `fu_req` and `cycle_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | Period start strobe |
| period_len | input | CNT_W | Cycle budget of one pass |
| prog_we | input | 1 | Program memory write enable |
| prog_waddr | input | PROG_AW | Program slot to write |
| prog_wdata | input | 28 | Command word to write |
| var_we | input | 1 | Variable RAM write enable |
| var_waddr | input | 8 | Variable address to write |
| var_wdata | input | DATA_W | Variable value to write |
| var_raddr | input | 8 | Variable address to read |
| var_rdata | output | DATA_W | Variable value read |
| fu_req | output | 1 | Request to the function unit |
| fu_sel | output | 4 | Function type selected |
| fu_a | output | DATA_W | First operand |
| fu_b | output | DATA_W | Second operand |
| fu_ack | input | 1 | Function unit completion |
| fu_result | input | DATA_W | Function unit result |
| busy | output | 1 | Pass in progress |
| overrun | output | 1 | Sticky budget or strobe overrun |
| cycle_cnt | output | CNT_W | Cycles used by the current or last pass |

## Verification
The bench runs a chained three-command program for every pairing of four function types with acknowledge delays from zero to three cycles. Each run uses several operand pairs, so a wrong operand order, a missing write-back or a miscounted wait cycle each shows up as a different wrong value or count. The budget is tried at exactly the needed length, at one cycle less, and at a length that ends the pass in the middle of its second command. These three runs separate an off-by-one budget compare from a write that leaks through during an abort. A strobe in mid-pass, host writes during a pass, and a stop command in slot 0 check that late strobes are dropped, that host writes are blocked and that fetching starts at slot 0.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 8;
  localparam int CMD_W  = OP_W + 3 * ADDR_W;
  localparam logic [OP_W-1:0] OP_STOP = 4'hF;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] src_a;
    logic [ADDR_W-1:0] src_b;
    logic [ADDR_W-1:0] dst;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_OPER  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/fseq_prog_mem.sv
module fseq_prog_mem #(
  parameter int AW = 6,
  parameter int W  = 28
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fseq_var_ram.sv
module fseq_var_ram #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NRD = 3
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PROG_AW = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_tick,
  input  logic [CNT_W-1:0]   period_len,
  output logic [PROG_AW-1:0] prog_addr,
  input  logic [CMD_W-1:0]   prog_word,
  output logic [ADDR_W-1:0]  rd_addr_a,
  output logic [ADDR_W-1:0]  rd_addr_b,
  input  logic [DATA_W-1:0]  rd_data_a,
  input  logic [DATA_W-1:0]  rd_data_b,
  output logic               fu_req,
  output logic [OP_W-1:0]    fu_sel,
  output logic [DATA_W-1:0]  fu_a,
  output logic [DATA_W-1:0]  fu_b,
  input  logic               fu_ack,
  input  logic [DATA_W-1:0]  fu_result,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               busy,
  output logic               overrun,
  output logic [CNT_W-1:0]   cycle_cnt
);
  seq_state_t         state_q, state_n;
  logic [PROG_AW-1:0] pc_q, pc_n;
  cmd_t               cmd_q;
  cmd_t               fetched;
  logic [DATA_W-1:0]  opa_q, opb_q;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               ovr_q, ovr_n;
  logic               cmd_en, opr_en;
  logic               budget_hit;

  assign fetched    = cmd_t'(prog_word);
  assign busy       = (state_q != ST_IDLE);
  assign budget_hit = busy && (cnt_q == period_len);

  always_comb begin
    state_n = state_q;
    pc_n    = pc_q;
    cnt_n   = cnt_q;
    ovr_n   = ovr_q;
    cmd_en  = 1'b0;
    opr_en  = 1'b0;
    wr_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pwm_tick) begin
          state_n = ST_FETCH;
          pc_n    = '0;
          cnt_n   = '0;
        end
      end
      ST_FETCH: begin
        cmd_en  = 1'b1;
        cnt_n   = cnt_q + 1'b1;
        state_n = (fetched.op == OP_STOP) ? ST_IDLE : ST_OPER;
      end
      ST_OPER: begin
        opr_en  = 1'b1;
        cnt_n   = cnt_q + 1'b1;
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        cnt_n = cnt_q + 1'b1;
        if (fu_ack) begin
          wr_en   = 1'b1;
          pc_n    = pc_q + 1'b1;
          state_n = ST_FETCH;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (busy && pwm_tick) begin
      ovr_n = 1'b1;
    end
    if (budget_hit) begin
      state_n = ST_IDLE;
      pc_n    = pc_q;
      cnt_n   = cnt_q;
      cmd_en  = 1'b0;
      opr_en  = 1'b0;
      wr_en   = 1'b0;
      ovr_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
      ovr_q   <= 1'b0;
      cmd_q   <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else begin
      state_q <= state_n;
      pc_q    <= pc_n;
      cnt_q   <= cnt_n;
      ovr_q   <= ovr_n;
      if (cmd_en) begin
        cmd_q <= fetched;
      end
      if (opr_en) begin
        opa_q <= rd_data_a;
        opb_q <= rd_data_b;
      end
    end
  end

  assign prog_addr = pc_q;
  assign rd_addr_a = cmd_q.src_a;
  assign rd_addr_b = cmd_q.src_b;
  assign fu_req    = (state_q == ST_WAIT) && !budget_hit;
  assign fu_sel    = cmd_q.op;
  assign fu_a      = opa_q;
  assign fu_b      = opb_q;
  assign wr_addr   = cmd_q.dst;
  assign wr_data   = fu_result;
  assign overrun   = ovr_q;
  assign cycle_cnt = cnt_q;
endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PROG_AW = 6,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_tick,
  input  logic [CNT_W-1:0]   period_len,
  input  logic               prog_we,
  input  logic [PROG_AW-1:0] prog_waddr,
  input  logic [CMD_W-1:0]   prog_wdata,
  input  logic               var_we,
  input  logic [ADDR_W-1:0]  var_waddr,
  input  logic [DATA_W-1:0]  var_wdata,
  input  logic [ADDR_W-1:0]  var_raddr,
  output logic [DATA_W-1:0]  var_rdata,
  output logic               fu_req,
  output logic [OP_W-1:0]    fu_sel,
  output logic [DATA_W-1:0]  fu_a,
  output logic [DATA_W-1:0]  fu_b,
  input  logic               fu_ack,
  input  logic [DATA_W-1:0]  fu_result,
  output logic               busy,
  output logic               overrun,
  output logic [CNT_W-1:0]   cycle_cnt
);
  localparam int NRD = 3;

  logic [PROG_AW-1:0]        prog_addr;
  logic [CMD_W-1:0]          prog_word;
  logic [ADDR_W-1:0]         rd_addr_a, rd_addr_b;
  logic [NRD-1:0][ADDR_W-1:0] ram_raddr;
  logic [NRD-1:0][DATA_W-1:0] ram_rdata;
  logic                      eng_wr;
  logic [ADDR_W-1:0]         eng_waddr;
  logic [DATA_W-1:0]         eng_wdata;
  logic                      ram_we;
  logic [ADDR_W-1:0]         ram_waddr;
  logic [DATA_W-1:0]         ram_wdata;
  logic                      prog_we_gated;

  assign prog_we_gated = prog_we && !busy;
  assign ram_we        = eng_wr || (var_we && !busy);
  assign ram_waddr     = eng_wr ? eng_waddr : var_waddr;
  assign ram_wdata     = eng_wr ? eng_wdata : var_wdata;
  assign ram_raddr[0]  = rd_addr_a;
  assign ram_raddr[1]  = rd_addr_b;
  assign ram_raddr[2]  = var_raddr;
  assign var_rdata     = ram_rdata[2];

  fseq_prog_mem #(.AW(PROG_AW), .W(CMD_W)) u_prog (
    .clk   (clk),
    .we    (prog_we_gated),
    .waddr (prog_waddr),
    .wdata (prog_wdata),
    .raddr (prog_addr),
    .rdata (prog_word)
  );

  fseq_var_ram #(.AW(ADDR_W), .DW(DATA_W), .NRD(NRD)) u_vars (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  fseq_ctrl #(.DATA_W(DATA_W), .PROG_AW(PROG_AW), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_tick   (pwm_tick),
    .period_len (period_len),
    .prog_addr  (prog_addr),
    .prog_word  (prog_word),
    .rd_addr_a  (rd_addr_a),
    .rd_addr_b  (rd_addr_b),
    .rd_data_a  (ram_rdata[0]),
    .rd_data_b  (ram_rdata[1]),
    .fu_req     (fu_req),
    .fu_sel     (fu_sel),
    .fu_a       (fu_a),
    .fu_b       (fu_b),
    .fu_ack     (fu_ack),
    .fu_result  (fu_result),
    .wr_en      (eng_wr),
    .wr_addr    (eng_waddr),
    .wr_data    (eng_wdata),
    .busy       (busy),
    .overrun    (overrun),
    .cycle_cnt  (cycle_cnt)
  );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_tick,
  input logic              busy,
  input logic              overrun,
  input logic              fu_req,
  input logic              fu_ack,
  input logic [3:0]        fu_sel,
  input logic [DATA_W-1:0] fu_a,
  input logic [DATA_W-1:0] fu_b,
  input logic [CNT_W-1:0]  cycle_cnt,
  input logic [CNT_W-1:0]  period_len
);
  logic [CNT_W-1:0] cnt_next;
  assign cnt_next = cycle_cnt + 1'b1;

  p_req_in_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fu_req |-> busy);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_req && !fu_ack && (cnt_next != period_len)) |=>
      (fu_req && $stable(fu_sel) && $stable(fu_a) && $stable(fu_b)));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwm_tick) |=> (busy && (cycle_cnt == '0)));

  p_budget_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cycle_cnt <= period_len));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cycle_cnt == period_len)) |=> (!busy && overrun));

  p_late_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pwm_tick) |=> overrun);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind fseq_top fseq_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_tick   (pwm_tick),
  .busy       (busy),
  .overrun    (overrun),
  .fu_req     (fu_req),
  .fu_ack     (fu_ack),
  .fu_sel     (fu_sel),
  .fu_a       (fu_a),
  .fu_b       (fu_b),
  .cycle_cnt  (cycle_cnt),
  .period_len (period_len)
);

// File: tb/fseq_top_tb.sv
module fseq_top_tb;
  localparam int DW = 16;
  localparam int PAW = 6;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_tick = 1'b0;
  logic [CW-1:0] period_len = 16'd1000;
  logic          prog_we = 1'b0;
  logic [PAW-1:0] prog_waddr = '0;
  logic [27:0]   prog_wdata = '0;
  logic          var_we = 1'b0;
  logic [7:0]    var_waddr = '0;
  logic [DW-1:0] var_wdata = '0;
  logic [7:0]    var_raddr = '0;
  logic [DW-1:0] var_rdata;
  logic          fu_req;
  logic [3:0]    fu_sel;
  logic [DW-1:0] fu_a, fu_b;
  logic          fu_ack;
  logic [DW-1:0] fu_result;
  logic          busy, overrun;
  logic [CW-1:0] cycle_cnt;

  int n_checks = 0;
  int n_fail = 0;
  int lat = 0;
  logic [3:0] wcnt = '0;

  always #4 clk = ~clk;

  fseq_top #(.DATA_W(DW), .PROG_AW(PAW), .CNT_W(CW)) u_dut (.*);

  // bench model of the function unit
  function automatic logic [DW-1:0] unit_fn(input logic [3:0] s, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (s)
      4'd1: unit_fn = a + b;
      4'd2: unit_fn = a - b;
      4'd3: unit_fn = a ^ b;
      4'd4: unit_fn = a & b;
      default: unit_fn = a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!fu_req || fu_ack) wcnt <= '0;
    else wcnt <= wcnt + 1'b1;
  end
  assign fu_ack    = fu_req && (wcnt == lat[3:0]);
  assign fu_result = unit_fn(fu_sel, fu_a, fu_b);

  function automatic logic [27:0] mk(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input logic [7:0] d);
    mk = {op, a, b, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wprog(input int slot, input logic [27:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_waddr = slot[PAW-1:0]; prog_wdata = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic wvar(input logic [7:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    var_we = 1'b1; var_waddr = a; var_wdata = v;
    @(negedge clk);
    var_we = 1'b0;
  endtask

  task automatic rvar(input logic [7:0] a, output logic [DW-1:0] v);
    var_raddr = a;
    #1;
    v = var_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    pwm_tick = 1'b1;
    @(negedge clk);
    pwm_tick = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic load_chain(input logic [3:0] op);
    wprog(0, mk(op, 8'd1, 8'd2, 8'd20));
    wprog(1, mk(4'd1, 8'd20, 8'd3, 8'd21));
    wprog(2, mk(op, 8'd4, 8'd5, 8'd22));
    wprog(3, mk(4'hF, 8'd0, 8'd0, 8'd0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] v, e20, e21, e22;
    logic [DW-1:0] av [4];
    logic [DW-1:0] bv [4];
    av[0] = 16'h0001; bv[0] = 16'h0002;
    av[1] = 16'hFFFF; bv[1] = 16'h0001;
    av[2] = 16'h1234; bv[2] = 16'hF0F0;
    av[3] = 16'h8000; bv[3] = 16'h8001;

    do_reset();
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 fu_req", fu_req, 0);
    chk("R10 cycle_cnt", cycle_cnt, 0);

    // R2: stop command in slot 0 ends pass after one cycle
    wprog(0, mk(4'hF, 8'd9, 8'd9, 8'd9));
    tick();
    wait_idle();
    chk("R2 stop at slot 0 cycles", cycle_cnt, 1);
    chk("R2 no overrun", overrun, 0);

    // R1 R3 R4 R5: sweep opcodes, delays and operand pairs
    for (int op = 1; op <= 4; op++) begin
      load_chain(op[3:0]);
      for (int l = 0; l < 4; l++) begin
        for (int p = 0; p < 4; p++) begin
          lat = l;
          wvar(8'd1, av[p]); wvar(8'd2, bv[p]);
          wvar(8'd3, bv[(p+1)%4]);
          wvar(8'd4, av[(p+2)%4]); wvar(8'd5, bv[(p+3)%4]);
          e20 = unit_fn(op[3:0], av[p], bv[p]);
          e21 = e20 + bv[(p+1)%4];
          e22 = unit_fn(op[3:0], av[(p+2)%4], bv[(p+3)%4]);
          tick();
          wait_idle();
          rvar(8'd20, v); chk("R3 result of first command", v, e20);
          rvar(8'd21, v); chk("R4 chained result", v, e21);
          rvar(8'd22, v); chk("R4 reused opcode result", v, e22);
          chk("R5 cycle count", cycle_cnt, 3*3 + 3*l + 1);
          chk("R5 no overrun", overrun, 0);
        end
      end
    end

    // R6 budget exactly met
    lat = 0;
    load_chain(4'd1);
    period_len = 16'd10;
    tick(); wait_idle();
    chk("R6 exact budget no overrun", overrun, 0);
    chk("R6 exact budget cycles", cycle_cnt, 10);

    // R6 one cycle short
    do_reset();
    period_len = 16'd9;
    tick(); wait_idle();
    chk("R6 short budget overrun", overrun, 1);
    chk("R6 short budget cycles", cycle_cnt, 9);

    // R6 abort in the second command: no write of its result
    do_reset();
    wvar(8'd1, 16'h0100); wvar(8'd2, 16'h0023);
    wvar(8'd20, 16'hDEAD); wvar(8'd21, 16'hBEEF);
    period_len = 16'd4;
    tick(); wait_idle();
    rvar(8'd20, v); chk("R6 write before abort", v, 16'h0123);
    rvar(8'd21, v); chk("R6 no write after abort", v, 16'hBEEF);
    chk("R6 abort overrun", overrun, 1);
    chk("R6 abort cycles", cycle_cnt, 4);
    chk("R6 abort busy low", busy, 0);
    chk("R6 abort req low", fu_req, 0);

    // R7 late strobe ignored, pass continues
    do_reset();
    period_len = 16'd1000;
    lat = 3;
    wvar(8'd1, 16'h0005); wvar(8'd2, 16'h0007); wvar(8'd3, 16'h0010);
    wvar(8'd4, 16'h0002); wvar(8'd5, 16'h0003);
    tick();
    @(negedge clk); @(negedge clk);
    tick();
    wait_idle();
    chk("R7 overrun on late strobe", overrun, 1);
    chk("R7 pass not restarted", cycle_cnt, 19);
    rvar(8'd21, v); chk("R7 results intact", v, 16'h001C);

    // R8 sticky across a clean pass
    tick(); wait_idle();
    chk("R8 overrun sticky", overrun, 1);

    // R9 host writes blocked during a pass
    do_reset();
    wvar(8'd30, 16'h0055);
    tick();
    @(negedge clk);
    var_we = 1'b1; var_waddr = 8'd30; var_wdata = 16'h1234;
    prog_we = 1'b1; prog_waddr = 6'd3; prog_wdata = mk(4'd1, 8'd1, 8'd1, 8'd30);
    @(negedge clk);
    var_we = 1'b0; prog_we = 1'b0;
    chk("R9 still busy during write", busy, 1);
    wait_idle();
    rvar(8'd30, v); chk("R9 variable write ignored", v, 16'h0055);
    tick(); wait_idle();
    chk("R9 program write ignored", cycle_cnt, 19);
    rvar(8'd30, v); chk("R9 variable unchanged after pass", v, 16'h0055);
    chk("R9 no overrun", overrun, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule